// File: doc/BRIEF.md
# Shared-Memory Write/Read-Back Engine

This block lets a host processor and a hardware accelerator exercise one shared external memory. The host programs a base address, a write count and a read count through a small 32-bit register file reached over an AXI4-Lite slave port, then sets a start bit. The engine stores an ascending sequence of words at the bottom of the buffer. It then reads a second block of words that sits directly after the written block and adds them into a running total.

All memory traffic, in both directions, goes through a single AXI4 master port. Each transfer is a single beat, and only one transfer is in flight at any time. While a run is going, the host can poll a progress code, a live counter for each phase, the running sum and a result register. These show where the engine is and whether it finished cleanly. A memory error response stops the run early, with the result register left clear.

Top module: `shmem_test_engine`

## Requirements
- R1: After reset the control word at 0x00 reads 0x4 (bit2 idle = 1, bit1 done = 0, bit0 busy = 0). Base, counts, progress, both counters, sum and result all read 0.
- R2: The base address (0x10), write count (0x18) and read count (0x20) are writable and read back what was written. Writes to the progress (0x28), write counter (0x30), read counter (0x38), sum (0x40) and result (0x48) offsets are ignored, and those registers keep their values.
- R3: Writing 1 to bit0 of 0x00 while idle starts a run. The start clears progress, both counters, the sum, the result and the done bit. The control word then reads 0x1 (busy).
- R4: In the write phase, word i of the effective write count W holds the value i and is written to base + 4*i, for i rising from 0. Every write has length 0, size 4 bytes, all strobes set and last set, and the next write address is issued only after the previous write response.
- R5: In the read phase, word j is read from base + 4*(W + j), one read at a time. The words read are summed modulo 2^32 into the register at 0x40.
- R6: The progress code at 0x28 is 0 during the write phase, 1 once the write phase is complete, and 2 once the read phase is complete. It never goes from 0 to 2 without passing through 1.
- R7: The counters at 0x30 and 0x38 hold the number of words completed so far in the write and read phases. They can be read while a run is in progress.
- R8: After a run completes without error, the result at 0x48 is 1 and the control word reads 0x6 (done and idle).
- R9: A start request that arrives while a run is busy is ignored. The run continues, and no extra memory writes are issued.
- R10: The effective write count is min(write count, 1024), and the effective read count is min(read count, 1024 - effective write count). Every access therefore stays inside the 4096-byte window above the base.
- R11: A write or read response of SLVERR (2'b10) or DECERR (2'b11) ends the run at once. No further transfers are issued, the result stays 0, done is set, and the counters and progress keep the values they held before the failing transfer.
- R12: A read address is never presented while a write address or write data is outstanding on the master port.
- R13: A zero effective count skips its phase. Progress still advances to 1 and then to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sAwaddr | input | 7 | Register write address |
| sAwvalid | input | 1 | Register write address valid |
| sAwready | output | 1 | Register write address ready |
| sWdata | input | 32 | Register write data |
| sWstrb | input | 4 | Register write byte strobes |
| sWvalid | input | 1 | Register write data valid |
| sWready | output | 1 | Register write data ready |
| sBresp | output | 2 | Register write response (always OKAY) |
| sBvalid | output | 1 | Register write response valid |
| sBready | input | 1 | Register write response ready |
| sAraddr | input | 7 | Register read address |
| sArvalid | input | 1 | Register read address valid |
| sArready | output | 1 | Register read address ready |
| sRdata | output | 32 | Register read data |
| sRresp | output | 2 | Register read response (always OKAY) |
| sRvalid | output | 1 | Register read data valid |
| sRready | input | 1 | Register read data ready |
| mAwaddr | output | 32 | Memory write address |
| mAwlen | output | 8 | Memory write length (0) |
| mAwsize | output | 3 | Memory write size (4 bytes) |
| mAwburst | output | 2 | Memory write burst type (INCR) |
| mAwvalid | output | 1 | Memory write address valid |
| mAwready | input | 1 | Memory write address ready |
| mWdata | output | 32 | Memory write data |
| mWstrb | output | 4 | Memory write strobes (all set) |
| mWlast | output | 1 | Memory write last (1) |
| mWvalid | output | 1 | Memory write data valid |
| mWready | input | 1 | Memory write data ready |
| mBresp | input | 2 | Memory write response |
| mBvalid | input | 1 | Memory write response valid |
| mBready | output | 1 | Memory write response ready |
| mAraddr | output | 32 | Memory read address |
| mArlen | output | 8 | Memory read length (0) |
| mArsize | output | 3 | Memory read size (4 bytes) |
| mArburst | output | 2 | Memory read burst type (INCR) |
| mArvalid | output | 1 | Memory read address valid |
| mArready | input | 1 | Memory read address ready |
| mRdata | input | 32 | Memory read data |
| mRresp | input | 2 | Memory read response |
| mRvalid | input | 1 | Memory read data valid |
| mRready | output | 1 | Memory read data ready |

## Verification
The hardest state to reach from the ports is a run caught in the middle: a start repeated while busy, and the live counters read before the first write completes. The bench model of the memory can delay its write response by a programmable number of cycles. With a 30-cycle delay, the host reads and the second start both land while the first write is still unacknowledged. The model also returns an error response at one chosen address, so an abort can be placed in either phase. A full 1024-word run drives the clamp to its upper limit.

// File: rtl/ste_pkg.sv
package ste_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_NEXT,
    ST_WR_WAIT,
    ST_RD_NEXT,
    ST_RD_WAIT
  } ste_state_e;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic clearRun;
    logic issueWrite;
    logic wrAccept;
    logic markWritten;
    logic issueRead;
    logic rdAccept;
    logic finishOk;
    logic finishErr;
  } ste_strobe_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  localparam logic [6:0] OFS_CTRL = 7'h00;
  localparam logic [6:0] OFS_BASE = 7'h10;
  localparam logic [6:0] OFS_WNUM = 7'h18;
  localparam logic [6:0] OFS_RNUM = 7'h20;
  localparam logic [6:0] OFS_PROG = 7'h28;
  localparam logic [6:0] OFS_WCNT = 7'h30;
  localparam logic [6:0] OFS_RCNT = 7'h38;
  localparam logic [6:0] OFS_SUM  = 7'h40;
  localparam logic [6:0] OFS_RET  = 7'h48;

  localparam logic [1:0] PROG_START   = 2'd0;
  localparam logic [1:0] PROG_WRITTEN = 2'd1;
  localparam logic [1:0] PROG_READ    = 2'd2;

endpackage

// File: rtl/ste_hostregs.sv
module ste_hostregs
  import ste_pkg::*;
#(
  parameter int LITE_AW = 7,
  parameter int DATA_W  = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LITE_AW-1:0] sAwaddr,
  input  logic               sAwvalid,
  output logic               sAwready,
  input  logic [DATA_W-1:0]  sWdata,
  input  logic [STRB_W-1:0]  sWstrb,
  input  logic               sWvalid,
  output logic               sWready,
  output logic [1:0]         sBresp,
  output logic               sBvalid,
  input  logic               sBready,
  input  logic [LITE_AW-1:0] sAraddr,
  input  logic               sArvalid,
  output logic               sArready,
  output logic [DATA_W-1:0]  sRdata,
  output logic [1:0]         sRresp,
  output logic               sRvalid,
  input  logic               sRready,
  output logic [DATA_W-1:0]  baseReg,
  output logic [DATA_W-1:0]  wrNumReg,
  output logic [DATA_W-1:0]  rdNumReg,
  output logic               startPulse,
  input  logic [1:0]         progress,
  input  logic [DATA_W-1:0]  wrCountExt,
  input  logic [DATA_W-1:0]  rdCountExt,
  input  logic [DATA_W-1:0]  readSum,
  input  logic               retVal,
  input  logic               runDone,
  input  logic               ctrlIdle
);

  logic              wrFire;
  logic              arFire;
  logic [DATA_W-1:0] readMux;

  function automatic logic [DATA_W-1:0] mergeBytes(
    input logic [DATA_W-1:0] oldVal,
    input logic [DATA_W-1:0] newVal,
    input logic [STRB_W-1:0] strb
  );
    logic [DATA_W-1:0] res;
    res = oldVal;
    for (int b = 0; b < STRB_W; b++) begin
      if (strb[b]) res[b*8 +: 8] = newVal[b*8 +: 8];
    end
    return res;
  endfunction

  assign wrFire   = sAwvalid & sWvalid & ~sBvalid;
  assign sAwready = wrFire;
  assign sWready  = wrFire;
  assign sBresp   = RESP_OKAY;
  assign arFire   = sArvalid & ~sRvalid;
  assign sArready = ~sRvalid;
  assign sRresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg    <= '0;
      wrNumReg   <= '0;
      rdNumReg   <= '0;
      startPulse <= 1'b0;
      sBvalid    <= 1'b0;
    end else begin
      startPulse <= 1'b0;
      if (sBvalid && sBready) sBvalid <= 1'b0;
      if (wrFire) begin
        sBvalid <= 1'b1;
        case (sAwaddr)
          LITE_AW'(OFS_CTRL): startPulse <= sWdata[0] & sWstrb[0];
          LITE_AW'(OFS_BASE): baseReg    <= mergeBytes(baseReg, sWdata, sWstrb);
          LITE_AW'(OFS_WNUM): wrNumReg   <= mergeBytes(wrNumReg, sWdata, sWstrb);
          LITE_AW'(OFS_RNUM): rdNumReg   <= mergeBytes(rdNumReg, sWdata, sWstrb);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sAraddr)
      LITE_AW'(OFS_CTRL): readMux = DATA_W'({ctrlIdle, runDone, ~ctrlIdle});
      LITE_AW'(OFS_BASE): readMux = baseReg;
      LITE_AW'(OFS_WNUM): readMux = wrNumReg;
      LITE_AW'(OFS_RNUM): readMux = rdNumReg;
      LITE_AW'(OFS_PROG): readMux = DATA_W'(progress);
      LITE_AW'(OFS_WCNT): readMux = wrCountExt;
      LITE_AW'(OFS_RCNT): readMux = rdCountExt;
      LITE_AW'(OFS_SUM):  readMux = readSum;
      LITE_AW'(OFS_RET):  readMux = DATA_W'(retVal);
      default:            readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sRvalid <= 1'b0;
      sRdata  <= '0;
    end else begin
      if (sRvalid && sRready) sRvalid <= 1'b0;
      if (arFire) begin
        sRvalid <= 1'b1;
        sRdata  <= readMux;
      end
    end
  end

endmodule

// File: rtl/ste_ctrl.sv
module ste_ctrl
  import ste_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        wrPhaseDone,
  input  logic        rdPhaseDone,
  input  logic        mBvalid,
  input  logic [1:0]  mBresp,
  input  logic        mRvalid,
  input  logic [1:0]  mRresp,
  output ste_strobe_t stb,
  output logic        mBready,
  output logic        mRready,
  output logic        ctrlIdle
);

  ste_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          stb.clearRun = 1'b1;
          nextState    = ST_WR_NEXT;
        end
      end
      ST_WR_NEXT: begin
        if (wrPhaseDone) begin
          stb.markWritten = 1'b1;
          nextState       = ST_RD_NEXT;
        end else begin
          stb.issueWrite = 1'b1;
          nextState      = ST_WR_WAIT;
        end
      end
      ST_WR_WAIT: begin
        if (mBvalid) begin
          if (mBresp == RESP_OKAY) begin
            stb.wrAccept = 1'b1;
            nextState    = ST_WR_NEXT;
          end else begin
            stb.finishErr = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      ST_RD_NEXT: begin
        if (rdPhaseDone) begin
          stb.finishOk = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          stb.issueRead = 1'b1;
          nextState     = ST_RD_WAIT;
        end
      end
      ST_RD_WAIT: begin
        if (mRvalid) begin
          if (mRresp == RESP_OKAY) begin
            stb.rdAccept = 1'b1;
            nextState    = ST_RD_NEXT;
          end else begin
            stb.finishErr = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign mBready  = (state == ST_WR_WAIT);
  assign mRready  = (state == ST_RD_WAIT);
  assign ctrlIdle = (state == ST_IDLE);

endmodule

// File: rtl/ste_datapath.sv
module ste_datapath
  import ste_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int WINDOW_WORDS = 1024,
  localparam int CNT_W       = $clog2(WINDOW_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ste_strobe_t       stb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] wrNum,
  input  logic [DATA_W-1:0] rdNum,
  output logic              mAwvalid,
  input  logic              mAwready,
  output logic [ADDR_W-1:0] mAwaddr,
  output logic              mWvalid,
  input  logic              mWready,
  output logic [DATA_W-1:0] mWdata,
  output logic              mArvalid,
  input  logic              mArready,
  output logic [ADDR_W-1:0] mAraddr,
  input  logic [DATA_W-1:0] mRdata,
  output logic              wrPhaseDone,
  output logic              rdPhaseDone,
  output logic [1:0]        progress,
  output logic [CNT_W-1:0]  wrCount,
  output logic [CNT_W-1:0]  rdCount,
  output logic [DATA_W-1:0] readSum,
  output logic              retVal,
  output logic              runDone
);

  localparam logic [DATA_W-1:0] WIN = DATA_W'(WINDOW_WORDS);

  logic [DATA_W-1:0] wClamp, rRoom, rClamp;
  logic [CNT_W-1:0]  effW, effR;

  assign wClamp = (wrNum > WIN) ? WIN : wrNum;
  assign rRoom  = WIN - wClamp;
  assign rClamp = (rdNum > rRoom) ? rRoom : rdNum;

  assign wrPhaseDone = (wrCount == effW);
  assign rdPhaseDone = (rdCount == effR);

  // run bookkeeping: counts, progress, sum, result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      effW     <= '0;
      effR     <= '0;
      wrCount  <= '0;
      rdCount  <= '0;
      readSum  <= '0;
      progress <= PROG_START;
      retVal   <= 1'b0;
      runDone  <= 1'b0;
    end else begin
      if (stb.clearRun) begin
        effW     <= CNT_W'(wClamp);
        effR     <= CNT_W'(rClamp);
        wrCount  <= '0;
        rdCount  <= '0;
        readSum  <= '0;
        progress <= PROG_START;
        retVal   <= 1'b0;
        runDone  <= 1'b0;
      end
      if (stb.wrAccept)    wrCount  <= wrCount + 1'b1;
      if (stb.markWritten) progress <= PROG_WRITTEN;
      if (stb.rdAccept) begin
        rdCount <= rdCount + 1'b1;
        readSum <= readSum + mRdata;
      end
      if (stb.finishOk) begin
        progress <= PROG_READ;
        retVal   <= 1'b1;
        runDone  <= 1'b1;
      end
      if (stb.finishErr) runDone <= 1'b1;
    end
  end

  // single-beat request channels
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mAwvalid <= 1'b0;
      mWvalid  <= 1'b0;
      mArvalid <= 1'b0;
      mAwaddr  <= '0;
      mWdata   <= '0;
      mAraddr  <= '0;
    end else begin
      if (mAwvalid && mAwready) mAwvalid <= 1'b0;
      if (mWvalid && mWready)   mWvalid  <= 1'b0;
      if (mArvalid && mArready) mArvalid <= 1'b0;
      if (stb.issueWrite) begin
        mAwvalid <= 1'b1;
        mWvalid  <= 1'b1;
        mAwaddr  <= baseAddr + (ADDR_W'(wrCount) << 2);
        mWdata   <= DATA_W'(wrCount);
      end
      if (stb.issueRead) begin
        mArvalid <= 1'b1;
        mAraddr  <= baseAddr + (ADDR_W'(effW + rdCount) << 2);
      end
    end
  end

endmodule

// File: rtl/shmem_test_engine.sv
module shmem_test_engine
  import ste_pkg::*;
#(
  parameter int LITE_AW      = 7,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int WINDOW_WORDS = 1024,
  localparam int STRB_W      = DATA_W / 8,
  localparam int CNT_W       = $clog2(WINDOW_WORDS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LITE_AW-1:0] sAwaddr,
  input  logic               sAwvalid,
  output logic               sAwready,
  input  logic [DATA_W-1:0]  sWdata,
  input  logic [STRB_W-1:0]  sWstrb,
  input  logic               sWvalid,
  output logic               sWready,
  output logic [1:0]         sBresp,
  output logic               sBvalid,
  input  logic               sBready,
  input  logic [LITE_AW-1:0] sAraddr,
  input  logic               sArvalid,
  output logic               sArready,
  output logic [DATA_W-1:0]  sRdata,
  output logic [1:0]         sRresp,
  output logic               sRvalid,
  input  logic               sRready,
  output logic [ADDR_W-1:0]  mAwaddr,
  output logic [7:0]         mAwlen,
  output logic [2:0]         mAwsize,
  output logic [1:0]         mAwburst,
  output logic               mAwvalid,
  input  logic               mAwready,
  output logic [DATA_W-1:0]  mWdata,
  output logic [STRB_W-1:0]  mWstrb,
  output logic               mWlast,
  output logic               mWvalid,
  input  logic               mWready,
  input  logic [1:0]         mBresp,
  input  logic               mBvalid,
  output logic               mBready,
  output logic [ADDR_W-1:0]  mAraddr,
  output logic [7:0]         mArlen,
  output logic [2:0]         mArsize,
  output logic [1:0]         mArburst,
  output logic               mArvalid,
  input  logic               mArready,
  input  logic [DATA_W-1:0]  mRdata,
  input  logic [1:0]         mRresp,
  input  logic               mRvalid,
  output logic               mRready
);

  localparam logic [2:0] BEAT_SIZE = 3'($clog2(STRB_W));

  ste_strobe_t       stb;
  logic [DATA_W-1:0] baseReg, wrNumReg, rdNumReg, readSum;
  logic [ADDR_W-1:0] baseAddrM;
  logic              startPulse, wrPhaseDone, rdPhaseDone;
  logic              retVal, runDone, ctrlIdle;
  logic [1:0]        progress;
  logic [CNT_W-1:0]  wrCount, rdCount;

  assign baseAddrM = ADDR_W'(baseReg);

  assign mAwlen   = 8'd0;
  assign mAwsize  = BEAT_SIZE;
  assign mAwburst = 2'b01;
  assign mWstrb   = '1;
  assign mWlast   = 1'b1;
  assign mArlen   = 8'd0;
  assign mArsize  = BEAT_SIZE;
  assign mArburst = 2'b01;

  ste_hostregs #(.LITE_AW(LITE_AW), .DATA_W(DATA_W)) i_hostregs (
    .clk        (clk),
    .rstN       (rstN),
    .sAwaddr    (sAwaddr),
    .sAwvalid   (sAwvalid),
    .sAwready   (sAwready),
    .sWdata     (sWdata),
    .sWstrb     (sWstrb),
    .sWvalid    (sWvalid),
    .sWready    (sWready),
    .sBresp     (sBresp),
    .sBvalid    (sBvalid),
    .sBready    (sBready),
    .sAraddr    (sAraddr),
    .sArvalid   (sArvalid),
    .sArready   (sArready),
    .sRdata     (sRdata),
    .sRresp     (sRresp),
    .sRvalid    (sRvalid),
    .sRready    (sRready),
    .baseReg    (baseReg),
    .wrNumReg   (wrNumReg),
    .rdNumReg   (rdNumReg),
    .startPulse (startPulse),
    .progress   (progress),
    .wrCountExt (DATA_W'(wrCount)),
    .rdCountExt (DATA_W'(rdCount)),
    .readSum    (readSum),
    .retVal     (retVal),
    .runDone    (runDone),
    .ctrlIdle   (ctrlIdle)
  );

  ste_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .wrPhaseDone (wrPhaseDone),
    .rdPhaseDone (rdPhaseDone),
    .mBvalid     (mBvalid),
    .mBresp      (mBresp),
    .mRvalid     (mRvalid),
    .mRresp      (mRresp),
    .stb         (stb),
    .mBready     (mBready),
    .mRready     (mRready),
    .ctrlIdle    (ctrlIdle)
  );

  ste_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WINDOW_WORDS(WINDOW_WORDS)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .baseAddr    (baseAddrM),
    .wrNum       (wrNumReg),
    .rdNum       (rdNumReg),
    .mAwvalid    (mAwvalid),
    .mAwready    (mAwready),
    .mAwaddr     (mAwaddr),
    .mWvalid     (mWvalid),
    .mWready     (mWready),
    .mWdata      (mWdata),
    .mArvalid    (mArvalid),
    .mArready    (mArready),
    .mAraddr     (mAraddr),
    .mRdata      (mRdata),
    .wrPhaseDone (wrPhaseDone),
    .rdPhaseDone (rdPhaseDone),
    .progress    (progress),
    .wrCount     (wrCount),
    .rdCount     (rdCount),
    .readSum     (readSum),
    .retVal      (retVal),
    .runDone     (runDone)
  );

endmodule

// File: rtl/ste_checker.sv
module ste_checker #(
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 11,
  parameter int WINDOW_WORDS = 1024
) (
  input logic              clk,
  input logic              rstN,
  input logic              mAwvalid,
  input logic              mAwready,
  input logic [ADDR_W-1:0] mAwaddr,
  input logic              mWvalid,
  input logic              mArvalid,
  input logic [ADDR_W-1:0] mAraddr,
  input logic              mBvalid,
  input logic              mBready,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [1:0]        progress,
  input logic              retVal,
  input logic              runDone,
  input logic [CNT_W-1:0]  wrCount
);

  localparam logic [ADDR_W-1:0] WINDOW_BYTES = ADDR_W'(WINDOW_WORDS * 4);

  // R12: no read request while a write request is pending
  a_r12_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    mArvalid |-> !(mAwvalid || mWvalid));

  // R4: write address held steady until accepted
  a_r4_aw_stable: assert property (@(posedge clk) disable iff (!rstN)
    (mAwvalid && !mAwready) |=> (mAwvalid && $stable(mAwaddr)));

  // R4: the write counter only advances on an accepted response
  a_r4_count_on_resp: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount != $past(wrCount) && wrCount != '0) |-> $past(mBvalid && mBready));

  // R10: write and read addresses stay inside the window
  a_r10_aw_window: assert property (@(posedge clk) disable iff (!rstN)
    mAwvalid |-> ((mAwaddr - baseAddr) < WINDOW_BYTES));

  a_r10_ar_window: assert property (@(posedge clk) disable iff (!rstN)
    mArvalid |-> ((mAraddr - baseAddr) < WINDOW_BYTES));

  // R6: final code is reached only from the written code
  a_r6_progress_order: assert property (@(posedge clk) disable iff (!rstN)
    (progress == 2'd2 && $past(progress) != 2'd2) |-> ($past(progress) == 2'd1));

  // R8: a success result is always accompanied by done
  a_r8_ret_implies_done: assert property (@(posedge clk) disable iff (!rstN)
    retVal |-> runDone);

endmodule

bind shmem_test_engine ste_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WINDOW_WORDS(WINDOW_WORDS)
) i_ste_checker (
  .clk      (clk),
  .rstN     (rstN),
  .mAwvalid (mAwvalid),
  .mAwready (mAwready),
  .mAwaddr  (mAwaddr),
  .mWvalid  (mWvalid),
  .mArvalid (mArvalid),
  .mAraddr  (mAraddr),
  .mBvalid  (mBvalid),
  .mBready  (mBready),
  .baseAddr (baseAddrM),
  .progress (progress),
  .retVal   (retVal),
  .runDone  (runDone),
  .wrCount  (wrCount)
);

// File: tb/test_shmem_test_engine.sv
module test_shmem_test_engine;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_2000;
  localparam logic [6:0] A_CTRL = 7'h00, A_BASE = 7'h10, A_WNUM = 7'h18, A_RNUM = 7'h20,
                         A_PROG = 7'h28, A_WCNT = 7'h30, A_RCNT = 7'h38, A_SUM = 7'h40,
                         A_RET = 7'h48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [6:0]  sAwaddr = '0, sAraddr = '0;
  logic        sAwvalid = 1'b0, sWvalid = 1'b0, sArvalid = 1'b0;
  logic [31:0] sWdata = '0;
  logic [3:0]  sWstrb = 4'hF;
  logic        sAwready, sWready, sBvalid, sArready, sRvalid;
  logic [1:0]  sBresp, sRresp;
  logic [31:0] sRdata;

  logic [31:0] mAwaddr, mWdata, mAraddr;
  logic [7:0]  mAwlen, mArlen;
  logic [2:0]  mAwsize, mArsize;
  logic [1:0]  mAwburst, mArburst;
  logic [3:0]  mWstrb;
  logic        mAwvalid, mWvalid, mWlast, mBready, mArvalid, mRready;
  logic        mAwready, mWready, mArready;

  // memory model state
  logic [31:0] mem [0:1023];
  logic        gotAw = 1'b0, gotW = 1'b0, bvalidR = 1'b0, arPend = 1'b0, rvalidR = 1'b0;
  logic [31:0] awAddrQ = '0, wDataQ = '0, arAddrQ = '0, rdataR = '0;
  logic [1:0]  brespR = '0, rrespR = '0;
  int          bCnt = 0, rCnt = 0;
  int          bDelay = 0, rDelay = 0;
  logic        errEn = 1'b0;
  logic [31:0] errAddr = '0;
  logic [31:0] expRdBase = BASE;

  // monitor counters
  logic        monClear = 1'b0;
  int awCount = 0, wCount = 0, arCount = 0, awBad = 0, arBad = 0, overlapBad = 0;

  int checks = 0, fails = 0;
  logic summaryDone = 1'b0;

  assign mAwready = !gotAw;
  assign mWready  = !gotW;
  assign mArready = !arPend && !rvalidR;

  shmem_test_engine i_shmem_test_engine (
    .clk(clk), .rstN(rstN),
    .sAwaddr(sAwaddr), .sAwvalid(sAwvalid), .sAwready(sAwready),
    .sWdata(sWdata), .sWstrb(sWstrb), .sWvalid(sWvalid), .sWready(sWready),
    .sBresp(sBresp), .sBvalid(sBvalid), .sBready(1'b1),
    .sAraddr(sAraddr), .sArvalid(sArvalid), .sArready(sArready),
    .sRdata(sRdata), .sRresp(sRresp), .sRvalid(sRvalid), .sRready(1'b1),
    .mAwaddr(mAwaddr), .mAwlen(mAwlen), .mAwsize(mAwsize), .mAwburst(mAwburst),
    .mAwvalid(mAwvalid), .mAwready(mAwready),
    .mWdata(mWdata), .mWstrb(mWstrb), .mWlast(mWlast), .mWvalid(mWvalid), .mWready(mWready),
    .mBresp(brespR), .mBvalid(bvalidR), .mBready(mBready),
    .mAraddr(mAraddr), .mArlen(mArlen), .mArsize(mArsize), .mArburst(mArburst),
    .mArvalid(mArvalid), .mArready(mArready),
    .mRdata(rdataR), .mRresp(rrespR), .mRvalid(rvalidR), .mRready(mRready)
  );

  // memory slave model with programmable latency and error injection
  always @(posedge clk) begin
    if (!rstN) begin
      gotAw <= 1'b0; gotW <= 1'b0; bvalidR <= 1'b0; arPend <= 1'b0; rvalidR <= 1'b0;
      bCnt <= 0; rCnt <= 0;
    end else begin
      if (mAwvalid && !gotAw) begin gotAw <= 1'b1; awAddrQ <= mAwaddr; end
      if (mWvalid && !gotW)   begin gotW <= 1'b1;  wDataQ <= mWdata;   end
      if (gotAw && gotW && !bvalidR) begin
        if (bCnt >= bDelay) begin
          mem[awAddrQ[11:2]] <= wDataQ;
          bvalidR <= 1'b1;
          brespR  <= (errEn && awAddrQ == errAddr) ? 2'b10 : 2'b00;
          bCnt    <= 0;
        end else bCnt <= bCnt + 1;
      end
      if (bvalidR && mBready) begin bvalidR <= 1'b0; gotAw <= 1'b0; gotW <= 1'b0; end
      if (mArvalid && mArready) begin arPend <= 1'b1; arAddrQ <= mAraddr; end
      if (arPend) begin
        if (rCnt >= rDelay) begin
          rvalidR <= 1'b1;
          rdataR  <= mem[arAddrQ[11:2]];
          rrespR  <= (errEn && arAddrQ == errAddr) ? 2'b11 : 2'b00;
          arPend  <= 1'b0;
          rCnt    <= 0;
        end else rCnt <= rCnt + 1;
      end
      if (rvalidR && mRready) rvalidR <= 1'b0;
    end
  end

  // protocol and address monitor
  always @(posedge clk) begin
    if (monClear) begin
      awCount <= 0; wCount <= 0; arCount <= 0; awBad <= 0; arBad <= 0; overlapBad <= 0;
    end else if (rstN) begin
      if (mAwvalid && mAwready) begin
        if (mAwaddr != BASE + 32'(awCount) * 4 || mAwlen != 8'd0 || mAwsize != 3'd2)
          awBad <= awBad + 1;
        awCount <= awCount + 1;
      end
      if (mWvalid && mWready) begin
        if (mWdata != 32'(wCount) || mWstrb != 4'hF || !mWlast) awBad <= awBad + 1;
        wCount <= wCount + 1;
      end
      if (mArvalid && mArready) begin
        if (mAraddr != expRdBase + 32'(arCount) * 4 || mArlen != 8'd0 || mArsize != 3'd2)
          arBad <= arBad + 1;
        arCount <= arCount + 1;
      end
      if (mArvalid && (mAwvalid || mWvalid || gotAw || gotW)) overlapBad <= overlapBad + 1;
    end
  end

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic liteWrite(input logic [6:0] addr, input logic [31:0] data);
    @(negedge clk);
    sAwaddr = addr; sWdata = data; sAwvalid = 1'b1; sWvalid = 1'b1;
    while (!sAwready) @(negedge clk);
    @(negedge clk);
    sAwvalid = 1'b0; sWvalid = 1'b0;
  endtask

  task automatic liteRead(input logic [6:0] addr, output logic [31:0] data);
    @(negedge clk);
    sAraddr = addr; sArvalid = 1'b1;
    while (!sArready) @(negedge clk);
    @(negedge clk);
    sArvalid = 1'b0;
    data = sRdata;
  endtask

  task automatic readCheck(input string req, input string what,
                           input logic [6:0] addr, input logic [31:0] exp);
    logic [31:0] v;
    liteRead(addr, v);
    checkEq(req, what, v, exp);
  endtask

  task automatic clearMonitor();
    @(negedge clk); monClear = 1'b1;
    @(negedge clk); monClear = 1'b0;
  endtask

  task automatic waitDone(input string req);
    logic [31:0] v;
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < 6000; k++) begin
      liteRead(A_CTRL, v);
      if (v[1]) begin seen = 1'b1; break; end
    end
    checkEq(req, "done reached", 32'(seen), 32'd1);
  endtask

  task automatic startRun(input logic [31:0] w, input logic [31:0] r, input logic [31:0] rdBase);
    expRdBase = rdBase;
    clearMonitor();
    liteWrite(A_WNUM, w);
    liteWrite(A_RNUM, r);
    liteWrite(A_CTRL, 32'h1);
  endtask

  task automatic testReset();
    readCheck("R1", "ctrl", A_CTRL, 32'h4);
    readCheck("R1", "base", A_BASE, 32'h0);
    readCheck("R1", "progress", A_PROG, 32'h0);
    readCheck("R1", "wcnt", A_WCNT, 32'h0);
    readCheck("R1", "rcnt", A_RCNT, 32'h0);
    readCheck("R1", "sum", A_SUM, 32'h0);
    readCheck("R1", "ret", A_RET, 32'h0);
  endtask

  task automatic testRegs();
    liteWrite(A_BASE, BASE);
    liteWrite(A_WNUM, 32'd77);
    liteWrite(A_RNUM, 32'd33);
    readCheck("R2", "base readback", A_BASE, BASE);
    readCheck("R2", "wnum readback", A_WNUM, 32'd77);
    readCheck("R2", "rnum readback", A_RNUM, 32'd33);
    liteWrite(A_PROG, 32'd5);
    liteWrite(A_SUM, 32'hDEAD);
    liteWrite(A_RET, 32'd1);
    readCheck("R2", "progress ro", A_PROG, 32'd0);
    readCheck("R2", "sum ro", A_SUM, 32'd0);
    readCheck("R2", "ret ro", A_RET, 32'd0);
  endtask

  task automatic testBasic();
    mem[5] = 32'd11; mem[6] = 32'd22; mem[7] = 32'd33; mem[8] = 32'd44;
    startRun(32'd5, 32'd4, BASE + 32'd20);
    waitDone("R8");
    for (int i = 0; i < 5; i++) checkEq("R4", "written word", mem[i], 32'(i));
    checkEq("R4", "write address/beat errors", 32'(awBad), 0);
    checkEq("R5", "read address errors", 32'(arBad), 0);
    readCheck("R5", "sum", A_SUM, 32'd110);
    readCheck("R6", "progress final", A_PROG, 32'd2);
    readCheck("R7", "wcnt final", A_WCNT, 32'd5);
    readCheck("R7", "rcnt final", A_RCNT, 32'd4);
    readCheck("R8", "ret", A_RET, 32'd1);
    readCheck("R8", "ctrl done idle", A_CTRL, 32'h6);
    checkEq("R12", "read while write pending", 32'(overlapBad), 0);
  endtask

  task automatic testBusyStart();
    bDelay = 30;
    mem[3] = 32'd100; mem[4] = 32'd200;
    startRun(32'd3, 32'd2, BASE + 32'd12);
    repeat (3) @(negedge clk);
    readCheck("R3", "progress cleared", A_PROG, 32'd0);
    readCheck("R3", "sum cleared", A_SUM, 32'd0);
    readCheck("R3", "ret cleared", A_RET, 32'd0);
    readCheck("R3", "ctrl busy", A_CTRL, 32'h1);
    readCheck("R7", "wcnt live", A_WCNT, 32'd0);
    liteWrite(A_CTRL, 32'h1);
    waitDone("R9");
    checkEq("R9", "write transfers", 32'(awCount), 32'd3);
    readCheck("R9", "wcnt", A_WCNT, 32'd3);
    readCheck("R5", "sum busy run", A_SUM, 32'd300);
    bDelay = 0;
  endtask

  task automatic testWrap();
    rDelay = 3;
    mem[1] = 32'hFFFF_FFF0; mem[2] = 32'h0000_0020;
    startRun(32'd1, 32'd2, BASE + 32'd4);
    waitDone("R5");
    readCheck("R5", "wrapped sum", A_SUM, 32'h10);
    checkEq("R5", "read address errors", 32'(arBad), 0);
    rDelay = 0;
  endtask

  task automatic testClamp();
    startRun(32'd2000, 32'd5, BASE + 32'd4096);
    waitDone("R10");
    readCheck("R10", "wcnt clamp", A_WCNT, 32'd1024);
    readCheck("R10", "rcnt clamp", A_RCNT, 32'd0);
    checkEq("R10", "reads issued", 32'(arCount), 0);
    checkEq("R10", "write addresses", 32'(awBad), 0);
    checkEq("R10", "last word", mem[1023], 32'd1023);
    startRun(32'd1020, 32'd10, BASE + 32'd4080);
    waitDone("R10");
    readCheck("R10", "rcnt room", A_RCNT, 32'd4);
    readCheck("R10", "sum tail", A_SUM, 32'd4086);
    checkEq("R10", "tail addresses", 32'(arBad), 0);
  endtask

  task automatic testZero();
    startRun(32'd0, 32'd3, BASE);
    waitDone("R13");
    readCheck("R13", "wcnt zero", A_WCNT, 32'd0);
    readCheck("R13", "sum", A_SUM, 32'd3);
    readCheck("R13", "progress", A_PROG, 32'd2);
    checkEq("R13", "no writes", 32'(awCount), 0);
    startRun(32'd2, 32'd0, BASE + 32'd8);
    waitDone("R13");
    readCheck("R13", "rcnt zero", A_RCNT, 32'd0);
    readCheck("R13", "progress w only", A_PROG, 32'd2);
    checkEq("R13", "no reads", 32'(arCount), 0);
  endtask

  task automatic testErrors();
    errEn = 1'b1; errAddr = BASE + 32'd8;
    startRun(32'd5, 32'd3, BASE + 32'd20);
    waitDone("R11");
    readCheck("R11", "wcnt at abort", A_WCNT, 32'd2);
    readCheck("R11", "ret", A_RET, 32'd0);
    readCheck("R11", "ctrl done idle", A_CTRL, 32'h6);
    readCheck("R11", "progress", A_PROG, 32'd0);
    checkEq("R11", "writes issued", 32'(awCount), 32'd3);
    checkEq("R11", "reads issued", 32'(arCount), 0);
    errAddr = BASE + 32'd12;
    startRun(32'd2, 32'd3, BASE + 32'd8);
    waitDone("R11");
    readCheck("R11", "rcnt at abort", A_RCNT, 32'd1);
    readCheck("R11", "progress read abort", A_PROG, 32'd1);
    readCheck("R11", "ret read abort", A_RET, 32'd0);
    checkEq("R11", "reads issued", 32'(arCount), 32'd2);
    errEn = 1'b0;
    checkEq("R12", "read while write pending", 32'(overlapBad), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testRegs();
    testBasic();
    testBusyStart();
    testWrap();
    testClamp();
    testZero();
    testErrors();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summaryDone) begin
      summaryDone = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

endmodule